// File: doc/BRIEF.md
# I2C Bus Status and Own-Address Monitor

This block observes already-synchronized SCL and SDA levels and keeps a 16-bit read-only status word for the processor side of an I2C controller. It recognizes start and stop conditions and keeps an active-low bus-busy flag. It shifts each received byte in MSB first and holds the most recently sampled data bit, which is normally the acknowledge bit.

The block compares the first byte after every start condition against a programmable 7-bit own address and the general-call value. It raises a flag on a match and another when arbitration is lost. It also holds the controller's master/slave and transmit/receive mode. The processor drives strobes to request a start as master, to select the transfer direction, to write the own address and to read the status word. Clock-rate generation, line driving and the transmit data path are outside this block.

Top module: `i2c_stat_mon`

## Requirements
- R1: After reset the status word reads 0x0100 (only bit 8, bus-busy-low, is set) and the own-address word reads 0x0000.
- R2: Bit 8 of the status word goes to 0 on a start condition (SDA falling while SCL is high) and back to 1 on a stop condition (SDA rising while SCL is high).
- R3: Status bits 7..0 take the SDA value on each SCL rising edge, shifting MSB first, for the eight data bits of a byte. The ninth (acknowledge) bit does not enter bits 7..0.
- R4: Status bit 12 always holds the SDA value sampled at the most recent SCL rising edge.
- R5: Status bit 11 is set when bits 7..1 of the first byte after a start equal the own address or equal 0 (general call). Later bytes of the same transfer never set it.
- R6: A one-cycle status-read strobe clears bit 11. If a match is flagged in the same cycle, the bit stays set.
- R7: Status bits 15..14 hold the mode: 00 slave receiver, 10 master receiver, 01 slave transmitter, 11 master transmitter. A start request loads 1 into bit 15 and the transmit-select value into bit 14. A direction write loads only bit 14.
- R8: In mode 11, if SDA is released high by the block but sampled low on an SCL rising edge, bit 10 is set and the mode becomes 00. A start request clears bit 10.
- R9: A stop condition forces the mode bits to 00.
- R10: Status bit 13 is set by a stop condition that occurs while the mode is 00. A later start condition clears it. A stop condition in any other mode leaves it at 0.
- R11: An own-address write loads the 7-bit value into bits 6..0 of the own-address word. Bits 15..7 of that word read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| sda_rel | input | 1 | 1 while the controller releases SDA high |
| start_req | input | 1 | Strobe: controller requests a start as master |
| start_tx | input | 1 | Direction loaded with start_req (1 = transmit) |
| dir_wr | input | 1 | Strobe: load transfer direction |
| dir_tx | input | 1 | Direction loaded with dir_wr (1 = transmit) |
| addr_wr | input | 1 | Strobe: load own address |
| addr_wdata | input | 7 | Own address value |
| stat_rd | input | 1 | Strobe: status word is being read |
| status | output | 16 | Mode, flags and received byte |
| own_addr | output | 16 | Own-address word |

## Verification
The bound checker checks several behaviours on every cycle: the busy flag's response to each start and stop condition, the mode clearing on stop, the arbitration-loss response, last-bit capture, read-clear of the address flag and own-address loading. Other behaviours depend on a whole transfer and are shown only by the bench's scenarios. These include MSB-first assembly of the byte, the address comparison restricted to the first byte, and general-call matching with either direction bit. The bench scenarios also cover set-wins-over-read on the address flag and the stop-at-slave flag's dependence on mode.

// File: rtl/i2c_stat_mon.sv
module i2c_stat_mon #(
  parameter int AW = 7,
  parameter logic [AW-1:0] GC_ADDR = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_i,
  input  logic          sda_i,
  input  logic          sda_rel,
  input  logic          start_req,
  input  logic          start_tx,
  input  logic          dir_wr,
  input  logic          dir_tx,
  input  logic          addr_wr,
  input  logic [AW-1:0] addr_wdata,
  input  logic          stat_rd,
  output logic [15:0]   status,
  output logic [15:0]   own_addr
);
  localparam int DW = AW + 1;
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] ACK_IDX  = CW'(DW);
  localparam logic [CW-1:0] LAST_IDX = CW'(DW - 1);

  logic          scl_q, sda_q;
  logic [CW-1:0] bit_cnt;
  logic          first_byte;
  logic [DW-1:0] rx_byte;
  logic [AW-1:0] own_a;
  logic [1:0]    mode;
  logic          busy_n, lrb, aas, lab, sts;

  always_ff @(posedge clk) begin
    scl_q <= scl_i;
    sda_q <= sda_i;
  end

  wire start_c  = scl_i & scl_q & sda_q & ~sda_i;
  wire stop_c   = scl_i & scl_q & ~sda_q & sda_i;
  wire scl_rise = scl_i & ~scl_q;

  wire [DW-1:0] nxt_byte = {rx_byte[DW-2:0], sda_i};
  wire addr_hit = scl_rise & first_byte & (bit_cnt == LAST_IDX) &
                  ((nxt_byte[DW-1:1] == own_a) | (nxt_byte[DW-1:1] == GC_ADDR));
  wire arb_lost = (mode == 2'b11) & sda_rel & scl_rise & ~sda_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_n     <= 1'b1;
      bit_cnt    <= '0;
      first_byte <= 1'b0;
      rx_byte    <= '0;
      lrb        <= 1'b0;
    end else begin
      if (start_c) busy_n <= 1'b0;
      else if (stop_c) busy_n <= 1'b1;

      if (start_c) begin
        bit_cnt    <= '0;
        first_byte <= 1'b1;
      end else if (scl_rise) begin
        bit_cnt <= (bit_cnt == ACK_IDX) ? '0 : bit_cnt + 1'b1;
        if (bit_cnt == LAST_IDX) first_byte <= 1'b0;
      end

      if (scl_rise) begin
        lrb <= sda_i;
        if (bit_cnt < ACK_IDX) rx_byte <= nxt_byte;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aas   <= 1'b0;
      lab   <= 1'b0;
      sts   <= 1'b0;
      mode  <= 2'b00;
      own_a <= '0;
    end else begin
      if (addr_hit) aas <= 1'b1;
      else if (stat_rd) aas <= 1'b0;

      if (arb_lost) lab <= 1'b1;
      else if (start_req) lab <= 1'b0;

      if (stop_c && mode == 2'b00) sts <= 1'b1;
      else if (start_c) sts <= 1'b0;

      if (arb_lost || stop_c) mode <= 2'b00;
      else if (start_req) mode <= {1'b1, start_tx};
      else if (dir_wr) mode[0] <= dir_tx;

      if (addr_wr) own_a <= addr_wdata;
    end
  end

  assign status   = {mode, sts, lrb, aas, lab, 1'b0, busy_n, rx_byte};
  assign own_addr = {{(16-AW){1'b0}}, own_a};
endmodule

// File: rtl/i2c_stat_mon_chk.sv
module i2c_stat_mon_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_i,
  input logic          sda_rel,
  input logic          stat_rd,
  input logic          addr_wr,
  input logic [AW-1:0] addr_wdata,
  input logic [15:0]   status,
  input logic [15:0]   own_addr
);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && $past(sda_i) && !sda_i) |=> !status[8]);
  // R2
  stop_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> status[8]);
  // R9
  stop_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i) && !$past(sda_i) && sda_i) |=> status[15:14] == 2'b00);
  // R8
  arb_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[15:14] == 2'b11 && sda_rel && scl_i && !$past(scl_i) && !sda_i)
      |=> (status[10] && status[15:14] == 2'b00));
  // R4
  last_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && !$past(scl_i)) |=> status[12] == $past(sda_i));
  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !(scl_i && !$past(scl_i))) |=> !status[11]);
  // R11
  own_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> own_addr[AW-1:0] == $past(addr_wdata));
endmodule

bind i2c_stat_mon i2c_stat_mon_chk #(.AW(AW)) u_chk (.*);

// File: tb/tb_i2c_stat_mon.sv
module tb_i2c_stat_mon;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {own address, first byte, expected match}
  localparam logic [15:0] VEC [NV] = '{
    {7'h50, 8'hA0, 1'b1},
    {7'h50, 8'hA1, 1'b1},
    {7'h50, 8'hA2, 1'b0},
    {7'h7F, 8'hFE, 1'b1},
    {7'h7F, 8'h00, 1'b1},
    {7'h12, 8'h01, 1'b1},
    {7'h12, 8'h80, 1'b0},
    {7'h00, 8'h00, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_i = 1'b1, sda_i = 1'b1, sda_rel = 1'b0;
  logic start_req = 1'b0, start_tx = 1'b0, dir_wr = 1'b0, dir_tx = 1'b0;
  logic addr_wr = 1'b0, stat_rd = 1'b0;
  logic [6:0] addr_wdata = '0;
  logic [15:0] status, own_addr;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stat_mon dut (.*);

  task automatic tick(); @(negedge clk); endtask

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    scl_i = 1; sda_i = 1; tick(); sda_i = 0; tick(); scl_i = 0; tick();
  endtask

  task automatic bus_stop();
    sda_i = 0; tick(); scl_i = 1; tick(); sda_i = 1; tick();
  endtask

  task automatic bus_bit(logic b);
    sda_i = b; tick(); scl_i = 1; tick(); scl_i = 0; tick();
  endtask

  task automatic bus_byte(logic [7:0] v);
    for (int i = 7; i >= 0; i--) bus_bit(v[i]);
  endtask

  task automatic pulse_rd(); stat_rd = 1; tick(); stat_rd = 0; tick(); endtask

  task automatic set_own(logic [6:0] a);
    addr_wdata = a; addr_wr = 1; tick(); addr_wr = 0; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    tick(); tick();
    // R1
    check("R1 status", status, 16'h0100);
    check("R1 own", own_addr, 16'h0000);
    rst_n = 1; tick();

    for (int k = 0; k < NV; k++) begin
      set_own(VEC[k][15:9]);
      check("R11 own word", own_addr, {9'b0, VEC[k][15:9]});
      bus_start();
      check("R2 busy after start", {15'b0, status[8]}, 16'h0000);
      bus_byte(VEC[k][8:1]);
      check("R3 byte", {8'b0, status[7:0]}, {8'b0, VEC[k][8:1]});
      check("R5 match", {15'b0, status[11]}, {15'b0, VEC[k][0]});
      bus_bit(~VEC[k][1]);
      check("R4 ack bit", {15'b0, status[12]}, {15'b0, ~VEC[k][1]});
      check("R3 ack not shifted", {8'b0, status[7:0]}, {8'b0, VEC[k][8:1]});
      pulse_rd();
      check("R6 read clears", {15'b0, status[11]}, 16'h0000);
      bus_stop();
      check("R2 busy after stop", {15'b0, status[8]}, 16'h0001);
      check("R10 stop in slave rx", {15'b0, status[13]}, 16'h0001);
    end

    // R10 start clears stop flag
    bus_start();
    check("R10 start clears", {15'b0, status[13]}, 16'h0000);
    // R5 later byte does not match
    set_own(7'h50);
    bus_byte(8'h10); bus_bit(1'b0);
    check("R5 first byte no match", {15'b0, status[11]}, 16'h0000);
    bus_byte(8'hA0); bus_bit(1'b0);
    check("R5 second byte ignored", {15'b0, status[11]}, 16'h0000);
    bus_stop();

    // R6 set wins over simultaneous read
    bus_start();
    for (int i = 7; i >= 1; i--) bus_bit(1'(8'hA0 >> i));
    sda_i = 0; tick(); scl_i = 1; stat_rd = 1; tick(); stat_rd = 0; scl_i = 0; tick();
    check("R6 set wins", {15'b0, status[11]}, 16'h0001);
    bus_bit(1'b0); bus_stop();

    // R7 mode encodings
    start_tx = 0; start_req = 1; tick(); start_req = 0; tick();
    check("R7 master rx", {14'b0, status[15:14]}, 16'h0002);
    dir_tx = 1; dir_wr = 1; tick(); dir_wr = 0; tick();
    check("R7 master tx", {14'b0, status[15:14]}, 16'h0003);

    // R8 arbitration loss
    sda_rel = 1; scl_i = 0; tick(); sda_i = 0; tick(); scl_i = 1; tick();
    check("R8 lost flag", {15'b0, status[10]}, 16'h0001);
    check("R8 mode cleared", {14'b0, status[15:14]}, 16'h0000);
    sda_rel = 0; scl_i = 0; tick(); sda_i = 1; tick(); scl_i = 1; tick();
    check("R8 flag holds", {15'b0, status[10]}, 16'h0001);
    start_tx = 1; start_req = 1; tick(); start_req = 0; tick();
    check("R8 start req clears", {15'b0, status[10]}, 16'h0000);
    check("R7 start loads tx", {14'b0, status[15:14]}, 16'h0003);

    // R9 stop clears mode, R10 no flag outside slave rx
    bus_start();
    dir_tx = 1; dir_wr = 1; tick(); dir_wr = 0; tick();
    bus_stop();
    check("R9 stop clears mode", {14'b0, status[15:14]}, 16'h0000);
    check("R10 no flag in tx mode", {15'b0, status[13]}, 16'h0000);
    dir_tx = 1; dir_wr = 1; tick(); dir_wr = 0; tick();
    check("R7 slave tx", {14'b0, status[15:14]}, 16'h0001);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule